// File: doc/BRIEF.md
# Power Averaging CIC Decimator

This block sits behind the power detector of a receive channel. It takes squared-magnitude samples, one per `in_valid` strobe, and sums each group of 1 to 4 of them. The group sums feed a single-stage integrate-and-dump decimator. That decimator adds a programmable number of group sums, right-shifts the total by a programmable scale, and emits the result as one gain-update sample with a one-cycle strobe.

The three parameters (group size, decimation ratio, scale) are held in active registers inside the block. The configuration inputs reach these registers only on a sync event that also requests initialization. A sync event without initialization only realigns the decimation count: the integrator keeps its contents and the parameters stay as they are. A sync event with initialization does three things:
- it clears the integrator;
- it drops any partly collected group;
- it loads the new parameters.

The decimator is a two-state machine. In `ST_ACCUM` it integrates group sums. When the group sum that completes a frame arrives, it moves to `ST_DUMP` (transition *frame_done*). `ST_DUMP` lasts one cycle, presents the scaled result, and returns to `ST_ACCUM` (transition *dump_return*). If a group sum arrives during that cycle it starts the next frame at once. With ratio 1 this means `ST_DUMP` repeats (transition *dump_again*). A sync event of either kind forces `ST_ACCUM` (transition *sync_restart*).

Top module: `pwr_avg_cic`

## Requirements
- R1: After reset `out_valid` is 0 and `out_sample` is 0. The active parameters are group size 1, ratio 1 and scale 0, so each accepted sample produces its own output.
- R2: The active group field G selects the group size. 00 means 1 sample, 01 means 2, 10 means 3 and 11 means 4. Each group of G+1 accepted samples yields one group sum, which is the plain sum of those samples.
- R3: The active ratio field N gives one output per N+1 group sums. The output is the sum of those group sums, right-shifted by the scale, keeping its low 32 bits. No output appears before the frame is complete.
- R4: The active scale field S (0 to 15) is applied as a logical right shift by S bits of the integrated total.
- R5: `out_valid` is high for exactly one cycle per result. It is raised by the first rising edge after the edge that captured the last sample of a frame. With ratio above 1 it is never high in two consecutive cycles.
- R6: A sync event with `sync_init` low restarts the decimation count. The next output comes after N+1 further group sums. The integrator contents, including a group sum arriving in the same cycle, are kept, and the parameters do not change.
- R7: A sync event with `sync_init` high clears the integrator and discards any partial group. A group sum arriving in that cycle is also discarded. The three configuration inputs become the active parameters from the next cycle.
- R8: Changes on `cfg_group`, `cfg_ratio` and `cfg_scale` have no effect unless a sync event with initialization occurs.
- R9: Values on `in_power` while `in_valid` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Power sample strobe |
| in_power | input | 32 | Unsigned power sample |
| cfg_group | input | 2 | Group size field (size minus 1) |
| cfg_ratio | input | 12 | Decimation ratio field (ratio minus 1) |
| cfg_scale | input | 4 | Output right-shift amount |
| sync_pulse | input | 1 | Sync event, one cycle |
| sync_init | input | 1 | Qualifies a sync event as an initialization |
| out_valid | output | 1 | Update sample strobe |
| out_sample | output | 32 | Scaled decimated update sample |

## Verification
The last sample of a frame is captured at edge t. Its group sum is registered at that same edge, and `out_valid` with `out_sample` is registered at edge t+1. The direct timing check therefore expects the strobe low just after edge t, high after edge t+1, and low again after edge t+2. All other result checks count strobes and take the last value through a monitor that samples 2 ns after each rising edge, with a few idle cycles left after every burst. A sync takes effect at the edge that captures it, so every scenario lets the pipeline drain before issuing a sync, unless the scenario is testing the same-cycle discard or keep behaviour.

// File: rtl/pwr_cic_pkg.sv
package pwr_cic_pkg;

    typedef enum logic {
        ST_ACCUM = 1'b0,
        ST_DUMP  = 1'b1
    } dec_state_e;

    typedef enum logic [1:0] {
        SY_NONE  = 2'd0,
        SY_ALIGN = 2'd1,
        SY_INIT  = 2'd2
    } sync_kind_e;

endpackage

// File: rtl/pwr_cic_cfg.sv
module pwr_cic_cfg #(
    parameter int GRP_W   = 2,
    parameter int RATIO_W = 12,
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [GRP_W-1:0]   cfg_group,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [SCALE_W-1:0] cfg_scale,
    output logic [GRP_W-1:0]   act_group,
    output logic [RATIO_W-1:0] act_ratio,
    output logic [SCALE_W-1:0] act_scale
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_group <= '0;
            act_ratio <= '0;
            act_scale <= '0;
        end else if (load) begin
            act_group <= cfg_group;
            act_ratio <= cfg_ratio;
            act_scale <= cfg_scale;
        end
    end

endmodule

// File: rtl/pwr_cic_avg.sv
module pwr_cic_avg #(
    parameter int IN_W  = 32,
    parameter int GRP_W = 2,
    localparam int SUM_W = IN_W + GRP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [GRP_W-1:0] grp_sel,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             grp_valid,
    output logic [SUM_W-1:0] grp_sum
);

    logic [GRP_W-1:0] cnt_q;
    logic [SUM_W-1:0] part_q;
    logic [SUM_W-1:0] part_next;

    always_comb begin
        part_next = part_q + SUM_W'(in_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            part_q    <= '0;
            grp_valid <= 1'b0;
            grp_sum   <= '0;
        end else if (clear) begin
            cnt_q     <= '0;
            part_q    <= '0;
            grp_valid <= 1'b0;
        end else if (in_valid) begin
            if (cnt_q == grp_sel) begin
                cnt_q     <= '0;
                part_q    <= '0;
                grp_valid <= 1'b1;
                grp_sum   <= part_next;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                part_q    <= part_next;
                grp_valid <= 1'b0;
            end
        end else begin
            grp_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pwr_cic_dec.sv
module pwr_cic_dec
    import pwr_cic_pkg::*;
#(
    parameter int SUM_W   = 34,
    parameter int RATIO_W = 12,
    localparam int ACC_W  = SUM_W + RATIO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  sync_kind_e         sync_kind,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               grp_valid,
    input  logic [SUM_W-1:0]   grp_sum,
    output logic               dump,
    output logic [ACC_W-1:0]   acc_q
);

    dec_state_e         st_q, st_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [ACC_W-1:0]   acc_d;
    logic [ACC_W-1:0]   base;
    logic [ACC_W-1:0]   addend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_ACCUM;
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            acc_q <= acc_d;
        end
    end

    always_comb begin
        addend = grp_valid ? ACC_W'(grp_sum) : '0;
        unique case (st_q)
            ST_ACCUM: base = acc_q;
            ST_DUMP:  base = '0;
            default:  base = '0;
        endcase
        st_d  = st_q;
        cnt_d = cnt_q;
        acc_d = acc_q;
        unique case (sync_kind)
            SY_INIT: begin
                st_d  = ST_ACCUM;
                cnt_d = '0;
                acc_d = '0;
            end
            SY_ALIGN: begin
                st_d  = ST_ACCUM;
                cnt_d = '0;
                acc_d = base + addend;
            end
            default: begin
                acc_d = base + addend;
                if (grp_valid) begin
                    if (cnt_q == ratio) begin
                        st_d  = ST_DUMP;
                        cnt_d = '0;
                    end else begin
                        st_d  = ST_ACCUM;
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    st_d = ST_ACCUM;
                end
            end
        endcase
    end

    always_comb begin
        unique case (st_q)
            ST_DUMP:  dump = 1'b1;
            ST_ACCUM: dump = 1'b0;
            default:  dump = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_cic_shift.sv
module pwr_cic_shift #(
    parameter int ACC_W   = 46,
    parameter int SCALE_W = 4,
    parameter int OUT_W   = 32
) (
    input  logic [ACC_W-1:0]   acc,
    input  logic [SCALE_W-1:0] scale,
    output logic [OUT_W-1:0]   result
);

    logic [ACC_W-1:0] shifted;

    always_comb begin
        shifted = acc >> scale;
        result  = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/pwr_avg_cic.sv
module pwr_avg_cic
    import pwr_cic_pkg::*;
#(
    parameter int IN_W    = 32,
    parameter int GRP_W   = 2,
    parameter int RATIO_W = 12,
    parameter int SCALE_W = 4,
    parameter int OUT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [IN_W-1:0]    in_power,
    input  logic [GRP_W-1:0]   cfg_group,
    input  logic [RATIO_W-1:0] cfg_ratio,
    input  logic [SCALE_W-1:0] cfg_scale,
    input  logic               sync_pulse,
    input  logic               sync_init,
    output logic               out_valid,
    output logic [OUT_W-1:0]   out_sample
);

    localparam int SUM_W = IN_W + GRP_W;
    localparam int ACC_W = SUM_W + RATIO_W;

    sync_kind_e         sync_kind;
    logic               init_evt;
    logic [GRP_W-1:0]   act_group;
    logic [RATIO_W-1:0] act_ratio;
    logic [SCALE_W-1:0] act_scale;
    logic               grp_valid;
    logic [SUM_W-1:0]   grp_sum;
    logic               dump;
    logic [ACC_W-1:0]   acc_q;

    always_comb begin
        if (!sync_pulse)     sync_kind = SY_NONE;
        else if (sync_init)  sync_kind = SY_INIT;
        else                 sync_kind = SY_ALIGN;
        init_evt = (sync_kind == SY_INIT);
    end

    pwr_cic_cfg #(.GRP_W(GRP_W), .RATIO_W(RATIO_W), .SCALE_W(SCALE_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(init_evt),
        .cfg_group(cfg_group), .cfg_ratio(cfg_ratio), .cfg_scale(cfg_scale),
        .act_group(act_group), .act_ratio(act_ratio), .act_scale(act_scale)
    );

    pwr_cic_avg #(.IN_W(IN_W), .GRP_W(GRP_W)) u_avg (
        .clk(clk), .rst_n(rst_n), .clear(init_evt), .grp_sel(act_group),
        .in_valid(in_valid), .in_data(in_power),
        .grp_valid(grp_valid), .grp_sum(grp_sum)
    );

    pwr_cic_dec #(.SUM_W(SUM_W), .RATIO_W(RATIO_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .sync_kind(sync_kind), .ratio(act_ratio),
        .grp_valid(grp_valid), .grp_sum(grp_sum),
        .dump(dump), .acc_q(acc_q)
    );

    pwr_cic_shift #(.ACC_W(ACC_W), .SCALE_W(SCALE_W), .OUT_W(OUT_W)) u_shift (
        .acc(acc_q), .scale(act_scale), .result(out_sample)
    );

    assign out_valid = dump;

endmodule

// File: rtl/pwr_avg_cic_chk.sv
module pwr_avg_cic_chk #(
    parameter int GRP_W   = 2,
    parameter int RATIO_W = 12,
    parameter int SCALE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sync_pulse,
    input logic               sync_init,
    input logic [GRP_W-1:0]   cfg_group,
    input logic [RATIO_W-1:0] cfg_ratio,
    input logic [SCALE_W-1:0] cfg_scale,
    input logic [GRP_W-1:0]   act_group,
    input logic [RATIO_W-1:0] act_ratio,
    input logic [SCALE_W-1:0] act_scale,
    input logic               grp_valid,
    input logic               out_valid
);

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && act_ratio != '0) |=> !out_valid);

    assert_load_params_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && sync_init) |=> (act_ratio == $past(cfg_ratio)
            && act_group == $past(cfg_group) && act_scale == $past(cfg_scale)));

    assert_init_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && sync_init) |=> (!out_valid && !grp_valid));

    assert_params_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_pulse && sync_init) |=> ($stable(act_ratio) && $stable(act_group)
            && $stable(act_scale)));

    assert_group_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_valid && act_group != '0) |=> !grp_valid);

    assert_out_after_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(grp_valid));

endmodule

bind pwr_avg_cic pwr_avg_cic_chk #(.GRP_W(GRP_W), .RATIO_W(RATIO_W), .SCALE_W(SCALE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .sync_init(sync_init),
    .cfg_group(cfg_group), .cfg_ratio(cfg_ratio), .cfg_scale(cfg_scale),
    .act_group(act_group), .act_ratio(act_ratio), .act_scale(act_scale),
    .grp_valid(grp_valid), .out_valid(out_valid)
);

// File: tb/pwr_avg_cic_tb.sv
module pwr_avg_cic_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_power = '0;
    logic [1:0]  cfg_group = '0;
    logic [11:0] cfg_ratio = '0;
    logic [3:0]  cfg_scale = '0;
    logic        sync_pulse = 1'b0;
    logic        sync_init = 1'b0;
    logic        out_valid;
    logic [31:0] out_sample;

    int          checks = 0;
    int          errors = 0;
    int          pulses = 0;
    logic [31:0] last_val = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pwr_avg_cic u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_power(in_power),
        .cfg_group(cfg_group), .cfg_ratio(cfg_ratio), .cfg_scale(cfg_scale),
        .sync_pulse(sync_pulse), .sync_init(sync_init),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always @(posedge clk) begin
        #2;
        if (rst_n && out_valid) begin
            pulses   = pulses + 1;
            last_val = out_sample;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic feed(input logic [31:0] v);
        @(negedge clk);
        in_valid = 1'b1;
        in_power = v;
        @(negedge clk);
        in_valid = 1'b0;
        in_power = '0;
    endtask

    task automatic burst4(input int n, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input logic [31:0] d);
        logic [31:0] v [4];
        v[0] = a; v[1] = b; v[2] = c; v[3] = d;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_power = v[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_power = '0;
        idle(4);
    endtask

    task automatic do_sync(input logic init, input logic [1:0] g,
                           input logic [11:0] r, input logic [3:0] s);
        @(negedge clk);
        cfg_group  = g;
        cfg_ratio  = r;
        cfg_scale  = s;
        sync_pulse = 1'b1;
        sync_init  = init;
        @(negedge clk);
        sync_pulse = 1'b0;
        sync_init  = 1'b0;
    endtask

    task automatic t_reset();
        idle(2);
        check("R1 reset valid", 32'(out_valid), 32'd0);
        check("R1 reset sample", out_sample, 32'd0);
    endtask

    task automatic t_timing();
        int p0;
        p0 = pulses;
        feed(32'd5);
        check("R5 low after capture edge", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R1 R5 high one edge later", 32'(out_valid), 32'd1);
        check("R1 default passes sample", out_sample, 32'd5);
        @(negedge clk);
        check("R5 single cycle", 32'(out_valid), 32'd0);
        idle(2);
        check("R5 one pulse", 32'(pulses - p0), 32'd1);
    endtask

    task automatic t_groups();
        int p0;
        do_sync(1'b1, 2'd3, 12'd1, 4'd2);
        p0 = pulses;
        burst4(4, 1, 2, 3, 4);
        check("R3 no output mid frame", 32'(pulses - p0), 32'd0);
        burst4(4, 5, 6, 7, 8);
        check("R2 R3 frame count", 32'(pulses - p0), 32'd1);
        check("R4 scaled sum 36>>2", last_val, 32'd9);
        do_sync(1'b1, 2'd1, 12'd0, 4'd0);
        p0 = pulses;
        burst4(4, 10, 20, 30, 40);
        check("R2 pairs give two outputs", 32'(pulses - p0), 32'd2);
        check("R2 pair sum", last_val, 32'd70);
    endtask

    task automatic t_back_to_back();
        int p0;
        do_sync(1'b1, 2'd0, 12'd0, 4'd0);
        p0 = pulses;
        burst4(4, 11, 22, 33, 44);
        check("R3 ratio 1 every sample", 32'(pulses - p0), 32'd4);
        check("R3 ratio 1 last value", last_val, 32'd44);
    endtask

    task automatic t_scale_edges();
        do_sync(1'b1, 2'd3, 12'd0, 4'd15);
        burst4(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R4 max shift", last_val, 32'h0007_FFFF);
        do_sync(1'b1, 2'd3, 12'd0, 4'd0);
        burst4(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check("R3 low 32 bits kept", last_val, 32'hFFFF_FFFC);
    endtask

    task automatic t_cfg_ignored();
        int p0;
        p0 = pulses;
        @(negedge clk);
        cfg_group = 2'd0;
        cfg_ratio = 12'd0;
        cfg_scale = 4'd5;
        in_power  = 32'd1000;
        idle(5);
        check("R9 data without strobe ignored", 32'(pulses - p0), 32'd0);
        burst4(4, 1, 2, 3, 4);
        check("R8 group size unchanged", 32'(pulses - p0), 32'd1);
        check("R8 R9 scale unchanged", last_val, 32'd10);
    endtask

    task automatic t_align();
        int p0;
        do_sync(1'b1, 2'd0, 12'd2, 4'd0);
        p0 = pulses;
        burst4(2, 10, 20, 0, 0);
        do_sync(1'b0, 2'd0, 12'd0, 4'd3);
        burst4(2, 1, 2, 0, 0);
        check("R6 count restarted, ratio kept", 32'(pulses - p0), 32'd0);
        feed(32'd3);
        idle(4);
        check("R6 one output after restart", 32'(pulses - p0), 32'd1);
        check("R6 integrator kept", last_val, 32'd36);
    endtask

    task automatic t_init();
        int p0;
        do_sync(1'b1, 2'd0, 12'd1, 4'd0);
        p0 = pulses;
        feed(32'd50);
        do_sync(1'b1, 2'd1, 12'd0, 4'd0);
        feed(32'd3);
        idle(3);
        check("R7 new group size", 32'(pulses - p0), 32'd0);
        feed(32'd4);
        idle(3);
        check("R7 output count", 32'(pulses - p0), 32'd1);
        check("R7 integrator cleared", last_val, 32'd7);
        do_sync(1'b1, 2'd3, 12'd0, 4'd0);
        burst4(2, 100, 200, 0, 0);
        do_sync(1'b1, 2'd1, 12'd0, 4'd0);
        p0 = pulses;
        burst4(2, 7, 8, 0, 0);
        check("R7 partial group dropped count", 32'(pulses - p0), 32'd1);
        check("R7 partial group dropped value", last_val, 32'd15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timing();
        t_groups();
        t_back_to_back();
        t_scale_edges();
        t_cfg_ignored();
        t_align();
        t_init();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule